// File: doc/BRIEF.md
# Interval Timer Pair with Interrupt Flags

This block is a byte-addressed pair of 16-bit down-counting interval timers of the kind found in classic parallel interface adapters. It advances once per bus cycle. The host CPU programs it through single-cycle byte reads and writes. The first timer has a 16-bit reload latch and two modes. In one-shot mode it interrupts once after a load. In free-running mode it reloads from the latch on every underflow and interrupts on each one, so its period is the latch value plus two cycles. The second timer is a simpler one-shot counter that is loaded directly by a write. Each timer owns one bit of a flag register. A matching bit in an enable register gates that flag onto an active-high interrupt request.

A high-byte write to the first timer only arms a load. The counter takes the full latch value on the next cycle. The CPU drives `instr_last` during the last cycle of each instruction. If the first timer raises an enabled interrupt on such a cycle, `irq_late` pulses for one cycle so that the CPU can defer servicing by one instruction.

Timer 1 has five states:
- `T1_IDLE`: stopped, the state after reset.
- `T1_LOAD`: the single cycle after a high-byte write.
- `T1_COUNT`: armed and decrementing.
- `T1_RELOAD`: the cycle after a free-running underflow.
- `T1_SPENT`: a one-shot that has fired and keeps decrementing.

Timer 1 transitions:
- A high-byte write moves any state to `T1_LOAD`.
- `T1_LOAD` moves to `T1_COUNT`.
- `T1_COUNT` at zero moves to `T1_RELOAD` in free-running mode and to `T1_SPENT` in one-shot mode.
- `T1_RELOAD` moves to `T1_COUNT`.

Timer 2 has three states, `T2_IDLE`, `T2_COUNT` and `T2_SPENT`. A high-byte write moves it to `T2_COUNT`, and `T2_COUNT` moves to `T2_SPENT` when the count passes zero.

Top module: `ivt_timer`

## Requirements
- R1: After a synchronous reset the following hold. `irq` and `irq_late` are 0. The flag register (offset 0xD) reads 0x00. The enable register (offset 0xE) reads 0x80. The mode register (offset 0xB) reads 0x00. The Timer 1 counter low byte (offset 0x0) reads 0x00. Both timers are stopped.
- R2: A write to offset 0x1 stores the byte in the Timer 1 high latch, clears the Timer 1 flag and starts the timer. A write to offset 0x0 or 0x2 stores the low latch. Offsets 0x2 and 0x3 read back the latch bytes.
- R3: The counter takes the full latch value on the cycle after the offset 0x1 write. A counter read in that cycle still returns the old value.
- R4: A read of offset 0x0 returns the Timer 1 counter low byte and clears the Timer 1 flag. Offset 0x1 reads the counter high byte.
- R5: With latch value N, the Timer 1 flag (bit 6 of offset 0xD) sets on the edge at which the counter leaves zero. That is the (N+2)th edge after the offset 0x1 write edge.
- R6: When mode bit 6 is 1 (free-running), the counter reloads from the latch on the cycle after it underflows. Flags then recur every N+2 cycles.
- R7: When mode bit 6 is 0 (one-shot), the flag sets only on the first underflow after a load. The counter keeps decrementing through 0xFFFF and 0xFFFE.
- R8: `irq_late` is high for exactly one cycle, the cycle after the edge on which the Timer 1 flag sets while both `instr_last` and the Timer 1 enable (bit 6) are high. Otherwise it is 0.
- R9: `irq` is high while any flag bit is set together with its enable bit. Bit 7 of the flag register reads the same value.
- R10: A write to offset 0xE with bit 7 = 1 sets the enables selected by bits 6 and 5. With bit 7 = 0 it clears them. Writing 1 to bit 6 or bit 5 of offset 0xD clears that flag. A flag that sets on the same edge as a read or write clear stays set.
- R11: A write to offset 0x5 loads the Timer 2 counter at once from {byte, low latch written at offset 0x4}, clears the Timer 2 flag (bit 5) and starts the timer. With count M the flag sets M+1 edges later, and only once.
- R12: A read of offset 0x4 returns the Timer 2 counter low byte and clears the Timer 2 flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Single-cycle register write strobe |
| re | input | 1 | Single-cycle register read strobe; read side effects occur at its edge |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| instr_last | input | 1 | High during the last cycle of the current CPU instruction |
| rdata | output | 8 | Combinational read data for `addr` |
| irq | output | 1 | Active-high interrupt request |
| irq_late | output | 1 | One-cycle pulse: Timer 1 interrupt raised on an instruction's last cycle |

## Verification
The bench measures the exact edge of each flag with latch values 2, 3, 4 and 5. A design that loads the counter on the write edge, or that drops the extra underflow cycle, would raise `irq` one cycle early and be caught by a check on the preceding cycle. The bench reads the counter in the cycle directly after the high write to expose an immediate load. In free-running mode it reads the counter after an underflow to expose a missing or late reload. In one-shot mode it reads the counter past 0xFFFF and then waits well beyond a period, which exposes a second interrupt or a counter that stops. It moves `instr_last` by one cycle around the underflow to show that `irq_late` tracks that exact cycle. It also toggles the enables around a pending flag to show that gating affects only `irq` and never the stored flag.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    localparam int AW = 4;

    localparam logic [AW-1:0] REG_T1_CLO = 4'h0;
    localparam logic [AW-1:0] REG_T1_CHI = 4'h1;
    localparam logic [AW-1:0] REG_T1_LLO = 4'h2;
    localparam logic [AW-1:0] REG_T1_LHI = 4'h3;
    localparam logic [AW-1:0] REG_T2_LO  = 4'h4;
    localparam logic [AW-1:0] REG_T2_HI  = 4'h5;
    localparam logic [AW-1:0] REG_MODE   = 4'hB;
    localparam logic [AW-1:0] REG_FLAGS  = 4'hD;
    localparam logic [AW-1:0] REG_ENABLE = 4'hE;

    localparam int MODE_FREE_BIT = 6;
    localparam int SEL_T1_BIT    = 6;
    localparam int SEL_T2_BIT    = 5;
    localparam int SEL_SET_BIT   = 7;

    typedef enum logic [2:0] {
        T1_IDLE,
        T1_LOAD,
        T1_COUNT,
        T1_RELOAD,
        T1_SPENT
    } t1_state_e;

    typedef enum logic [1:0] {
        T2_IDLE,
        T2_COUNT,
        T2_SPENT
    } t2_state_e;

endpackage

// File: rtl/ivt_t1.sv
module ivt_t1
    import ivt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lat_lo_we,
    input  logic          lat_hi_we,
    input  logic          start,
    input  logic          free_run,
    input  logic [7:0]    wdata,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] latch,
    output logic          underflow,
    output t1_state_e     state
);

    localparam int HW = CW - 8;

    t1_state_e nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= T1_IDLE;
        else     state <= nxt;
    end

    // next state and underflow event
    always_comb begin
        nxt       = state;
        underflow = 1'b0;
        unique case (state)
            T1_IDLE:   nxt = T1_IDLE;
            T1_LOAD:   nxt = T1_COUNT;
            T1_COUNT: begin
                if (cnt == '0) begin
                    underflow = 1'b1;
                    nxt       = free_run ? T1_RELOAD : T1_SPENT;
                end
            end
            T1_RELOAD: nxt = T1_COUNT;
            T1_SPENT:  nxt = T1_SPENT;
            default:   nxt = T1_IDLE;
        endcase
        if (start) begin
            nxt       = T1_LOAD;
            underflow = 1'b0;
        end
    end

    // latch and counter datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            latch <= '0;
            cnt   <= '0;
        end else begin
            if (lat_lo_we) latch[7:0]    <= wdata;
            if (lat_hi_we) latch[CW-1:8] <= HW'(wdata);
            unique case (state)
                T1_LOAD, T1_RELOAD: cnt <= latch;
                T1_COUNT, T1_SPENT: cnt <= cnt - 1'b1;
                default:            cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/ivt_t2.sv
module ivt_t2
    import ivt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lo_we,
    input  logic          start,
    input  logic [7:0]    wdata,
    output logic [CW-1:0] cnt,
    output logic          underflow
);

    localparam int HW = CW - 8;

    t2_state_e state, nxt;
    logic [7:0] lat_lo;

    always_ff @(posedge clk) begin
        if (rst) state <= T2_IDLE;
        else     state <= nxt;
    end

    always_comb begin
        nxt       = state;
        underflow = 1'b0;
        unique case (state)
            T2_IDLE:  nxt = T2_IDLE;
            T2_COUNT: begin
                if (cnt == '0) begin
                    underflow = 1'b1;
                    nxt       = T2_SPENT;
                end
            end
            T2_SPENT: nxt = T2_SPENT;
            default:  nxt = T2_IDLE;
        endcase
        if (start) begin
            nxt       = T2_COUNT;
            underflow = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_lo <= '0;
            cnt    <= '0;
        end else begin
            if (lo_we) lat_lo <= wdata;
            if (start)
                cnt <= {HW'(wdata), lat_lo};
            else if (state != T2_IDLE)
                cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/ivt_irq.sv
module ivt_irq (
    input  logic       clk,
    input  logic       rst,
    input  logic       t1_set,
    input  logic       t2_set,
    input  logic       t1_clr,
    input  logic       t2_clr,
    input  logic       en_we,
    input  logic       en_set_mode,
    input  logic [1:0] en_sel,
    input  logic       instr_last,
    output logic       t1_flag,
    output logic       t2_flag,
    output logic [1:0] ien,
    output logic       irq,
    output logic       irq_late
);

    always_ff @(posedge clk) begin
        if (rst) begin
            t1_flag  <= 1'b0;
            t2_flag  <= 1'b0;
            ien      <= '0;
            irq_late <= 1'b0;
        end else begin
            if (t1_set)      t1_flag <= 1'b1;
            else if (t1_clr) t1_flag <= 1'b0;
            if (t2_set)      t2_flag <= 1'b1;
            else if (t2_clr) t2_flag <= 1'b0;
            if (en_we)
                ien <= en_set_mode ? (ien | en_sel) : (ien & ~en_sel);
            irq_late <= t1_set & ien[1] & instr_last;
        end
    end

    assign irq = (t1_flag & ien[1]) | (t2_flag & ien[0]);

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic       re,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    input  logic       instr_last,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       irq_late
);

    logic [7:0]    mode;
    logic [CW-1:0] t1_cnt, t1_latch, t2_cnt;
    logic          t1_uf, t2_uf;
    logic          t1_flag, t2_flag;
    logic [1:0]    ien;
    t1_state_e     t1_state;

    logic wr_t1_hi, wr_t2_hi, t1_clr, t2_clr;

    assign wr_t1_hi = we && (addr == REG_T1_CHI);
    assign wr_t2_hi = we && (addr == REG_T2_HI);
    assign t1_clr   = wr_t1_hi
                    || (re && addr == REG_T1_CLO)
                    || (we && addr == REG_FLAGS && wdata[SEL_T1_BIT]);
    assign t2_clr   = wr_t2_hi
                    || (re && addr == REG_T2_LO)
                    || (we && addr == REG_FLAGS && wdata[SEL_T2_BIT]);

    always_ff @(posedge clk) begin
        if (rst)                        mode <= '0;
        else if (we && addr == REG_MODE) mode <= wdata;
    end

    ivt_t1 #(.CW(CW)) u_t1 (
        .clk       (clk),
        .rst       (rst),
        .lat_lo_we (we && (addr == REG_T1_CLO || addr == REG_T1_LLO)),
        .lat_hi_we (we && (addr == REG_T1_CHI || addr == REG_T1_LHI)),
        .start     (wr_t1_hi),
        .free_run  (mode[MODE_FREE_BIT]),
        .wdata     (wdata),
        .cnt       (t1_cnt),
        .latch     (t1_latch),
        .underflow (t1_uf),
        .state     (t1_state)
    );

    ivt_t2 #(.CW(CW)) u_t2 (
        .clk       (clk),
        .rst       (rst),
        .lo_we     (we && addr == REG_T2_LO),
        .start     (wr_t2_hi),
        .wdata     (wdata),
        .cnt       (t2_cnt),
        .underflow (t2_uf)
    );

    ivt_irq u_irq (
        .clk         (clk),
        .rst         (rst),
        .t1_set      (t1_uf),
        .t2_set      (t2_uf),
        .t1_clr      (t1_clr),
        .t2_clr      (t2_clr),
        .en_we       (we && addr == REG_ENABLE),
        .en_set_mode (wdata[SEL_SET_BIT]),
        .en_sel      ({wdata[SEL_T1_BIT], wdata[SEL_T2_BIT]}),
        .instr_last  (instr_last),
        .t1_flag     (t1_flag),
        .t2_flag     (t2_flag),
        .ien         (ien),
        .irq         (irq),
        .irq_late    (irq_late)
    );

    always_comb begin
        unique case (addr)
            REG_T1_CLO: rdata = t1_cnt[7:0];
            REG_T1_CHI: rdata = 8'(t1_cnt >> 8);
            REG_T1_LLO: rdata = t1_latch[7:0];
            REG_T1_LHI: rdata = 8'(t1_latch >> 8);
            REG_T2_LO:  rdata = t2_cnt[7:0];
            REG_T2_HI:  rdata = 8'(t2_cnt >> 8);
            REG_MODE:   rdata = mode;
            REG_FLAGS:  rdata = {irq, t1_flag, t2_flag, 5'b0};
            REG_ENABLE: rdata = {1'b1, ien, 5'b0};
            default:    rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk
    import ivt_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          we,
    input logic          re,
    input logic [3:0]    addr,
    input logic          irq,
    input logic          irq_late,
    input logic          t1_flag,
    input logic          t2_flag,
    input logic [1:0]    ien,
    input t1_state_e     t1_state,
    input logic [CW-1:0] t1_cnt,
    input logic [CW-1:0] t1_latch,
    input logic [CW-1:0] t2_cnt
);

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!irq && !irq_late)); // R1
    AST_HI_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (we && addr == REG_T1_CHI) |=> !t1_flag); // R2
    AST_LOAD_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (t1_state == T1_LOAD) |=> (t1_cnt == $past(t1_latch))); // R3
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (re && !we && addr == REG_T1_CLO && !(t1_state == T1_COUNT && t1_cnt == '0))
        |=> !t1_flag); // R4
    AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(t1_flag) |-> ($past(t1_cnt) == '0)); // R5
    AST_FREE_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (t1_state == T1_RELOAD) |=> (t1_cnt == $past(t1_latch))); // R6
    AST_ONESHOT_ONCE: assert property (@(posedge clk) disable iff (rst)
        (t1_state == T1_SPENT) |=> !$rose(t1_flag)); // R7
    AST_LATE_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_late |-> (t1_flag && ien[1])); // R8
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ien == 2'b00) |-> !irq); // R9
    AST_T2_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(t2_flag) |-> ($past(t2_cnt) == '0)); // R11

endmodule

bind ivt_timer ivt_timer_chk #(.CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .we       (we),
    .re       (re),
    .addr     (addr),
    .irq      (irq),
    .irq_late (irq_late),
    .t1_flag  (t1_flag),
    .t2_flag  (t2_flag),
    .ien      (ien),
    .t1_state (t1_state),
    .t1_cnt   (t1_cnt),
    .t1_latch (t1_latch),
    .t2_cnt   (t2_cnt)
);

// File: tb/ivt_timer_test.sv
module ivt_timer_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       we = 1'b0;
    logic       re = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       instr_last = 1'b0;
    logic [7:0] rdata;
    logic       irq, irq_late;

    int n_checks = 0;
    int n_fail   = 0;

    ivt_timer uut (
        .clk(clk), .rst(rst), .we(we), .re(re), .addr(addr), .wdata(wdata),
        .instr_last(instr_last), .rdata(rdata), .irq(irq), .irq_late(irq_late)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; we = 1'b0; re = 1'b0; instr_last = 1'b0;
        tick(2);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        re = 1'b1; addr = a;
        #1 v = rdata;
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic test_reset();
        logic [7:0] v;
        do_reset();
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 irq_late", {7'b0, irq_late}, 8'h00);
        rd(4'hD, v); chk("R1 flags", v, 8'h00);
        rd(4'hE, v); chk("R1 enables", v, 8'h80);
        rd(4'hB, v); chk("R1 mode", v, 8'h00);
        rd(4'h0, v); chk("R1 t1 count", v, 8'h00);
    endtask

    task automatic test_oneshot();
        logic [7:0] v;
        do_reset();
        wr(4'hE, 8'hC0);
        wr(4'h2, 8'h05);
        wr(4'h1, 8'h00);                               // n0
        rd(4'h0, v); chk("R3 not loaded yet", v, 8'h00);   // n0 -> n1
        rd(4'h0, v); chk("R3 loaded", v, 8'h05);           // n1 -> n2
        rd(4'h1, v); chk("R4 count high", v, 8'h00);       // n2 -> n3
        tick(3);
        chk("R5 before period", {7'b0, irq}, 8'h00);       // n6
        tick(1);
        chk("R5 flag at N+2", {7'b0, irq}, 8'h01);         // n7
        rd(4'h0, v); chk("R7 past zero", v, 8'hFF);        // n7 -> n8
        chk("R4 read clears", {7'b0, irq}, 8'h00);
        rd(4'h0, v); chk("R7 keeps counting", v, 8'hFE);
        tick(30);
        chk("R7 no second flag", {7'b0, irq}, 8'h00);
        rd(4'hD, v); chk("R7 flag reg idle", v, 8'h00);
    endtask

    task automatic test_freerun();
        logic [7:0] v;
        do_reset();
        wr(4'hB, 8'h40);
        wr(4'hE, 8'hC0);
        wr(4'h2, 8'h03);
        wr(4'h1, 8'h00);                               // n0
        tick(4);
        chk("R6 before first", {7'b0, irq}, 8'h00);
        tick(1);
        chk("R6 first flag", {7'b0, irq}, 8'h01);          // n5
        wr(4'hD, 8'h40);                               // n6
        chk("R10 write-one clears", {7'b0, irq}, 8'h00);
        rd(4'h0, v); chk("R6 reloaded", v, 8'h03);         // n6 -> n7
        tick(2);
        chk("R6 before second", {7'b0, irq}, 8'h00);       // n9
        tick(1);
        chk("R6 second flag", {7'b0, irq}, 8'h01);         // n10
        rd(4'hB, v); chk("R6 mode readback", v, 8'h40);
    endtask

    task automatic test_late();
        do_reset();
        wr(4'hE, 8'hC0);
        wr(4'h2, 8'h04);
        wr(4'h1, 8'h00);                               // n0, flag edge 6
        tick(5);
        instr_last = 1'b1;
        tick(1);
        instr_last = 1'b0;                             // n6
        chk("R8 pulse", {7'b0, irq_late}, 8'h01);
        chk("R8 irq", {7'b0, irq}, 8'h01);
        tick(1);
        chk("R8 single cycle", {7'b0, irq_late}, 8'h00);
        wr(4'h1, 8'h00);                               // n0'
        tick(3);
        instr_last = 1'b1;
        tick(1);
        instr_last = 1'b0;
        tick(2);                                       // n6'
        chk("R8 wrong cycle irq", {7'b0, irq}, 8'h01);
        chk("R8 wrong cycle no pulse", {7'b0, irq_late}, 8'h00);
    endtask

    task automatic test_gating();
        logic [7:0] v;
        do_reset();
        wr(4'h2, 8'h02);
        wr(4'h1, 8'h00);                               // n0, flag edge 4
        tick(5);
        chk("R9 masked", {7'b0, irq}, 8'h00);
        rd(4'hD, v); chk("R9 pending masked", v, 8'h40);
        wr(4'hE, 8'hC0);
        chk("R9 enabled", {7'b0, irq}, 8'h01);
        rd(4'hD, v); chk("R9 bit7 active", v, 8'hC0);
        rd(4'hE, v); chk("R10 enable set", v, 8'hC0);
        wr(4'hE, 8'h40);
        chk("R10 enable clear", {7'b0, irq}, 8'h00);
        rd(4'hE, v); chk("R10 enable read", v, 8'h80);
        wr(4'hE, 8'hC0);
        chk("R9 re-enabled", {7'b0, irq}, 8'h01);
        wr(4'h1, 8'h12);
        chk("R2 high write clears", {7'b0, irq}, 8'h00);
        rd(4'h3, v); chk("R2 high latch", v, 8'h12);
        rd(4'h2, v); chk("R2 low latch", v, 8'h02);
    endtask

    task automatic test_t2();
        logic [7:0] v;
        do_reset();
        wr(4'hE, 8'hA0);
        wr(4'h4, 8'h04);
        wr(4'h5, 8'h00);                               // n0, flag edge 5
        tick(4);
        chk("R11 before", {7'b0, irq}, 8'h00);
        tick(1);
        chk("R11 flag", {7'b0, irq}, 8'h01);               // n5
        rd(4'hD, v); chk("R11 flag bit", v, 8'hA0);        // n5 -> n6
        rd(4'h4, v); chk("R12 count low", v, 8'hFE);       // n6 -> n7
        chk("R12 read clears", {7'b0, irq}, 8'h00);
        tick(30);
        chk("R11 one-shot", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_oneshot();
        test_freerun();
        test_late();
        test_gating();
        test_t2();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule